// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block divides a gated oscillator clock down to a fixed periodic event and uses it to raise an interrupt. A rate register holds two fields: a prescaler selector that picks a power-of-two pre-division, and a modulus that divides that further by 1 to 16. At the end of every period a sticky flag is set. The interrupt output is driven while the flag is set and interrupts are enabled. Software clears the flag by writing a one to a clear bit in the control register.

The timer runs without a break. The next period starts on the same cycle the flag sets. Any write to the rate register starts the current period again from zero. A stop-mode input freezes the count, unless the control register allows the timer to keep running during stop. A prescaler selector of zero turns the timer off. The width of the prescaler is set by a parameter, so the base exponent can be made small for short test periods.

Top module: `rti_timer`

## Requirements
- R1: After reset, flag_o and irq_o are 0 and the rate register is zero, so the timer is off and no flag sets until a rate is written.
- R2: A rate write places the modulus M in bits [3:0] and the prescaler selector p in bits [6:4]. When p is not zero, the flag first sets exactly (M+1)*2^(PRE_BASE+p-1) counting cycles after the write edge.
- R3: While the timer runs, consecutive flag-set events are exactly one period apart, with no dead cycle. Clearing the flag between them does not move them.
- R4: A rate write clears the prescaler and divider counts, so the next flag-set falls one full period after that write and not at the old deadline.
- R5: With p = 0 the timer is stopped and the flag never sets.
- R6: irq_o equals flag_o AND the interrupt enable. The enable is bit 0 of a control write (wr_sel = 1).
- R7: A control write with bit 2 set clears the flag on that edge. A control write with bit 2 clear leaves the flag as it was. A control write never restarts the period.
- R8: If the period ends on the same edge as a flag-clear write, the flag ends up set.
- R9: While stop_in is high and the stop-continue bit (control bit 1) is 0, the counts hold. Each such cycle delays the next flag-set by one cycle.
- R10: While stop_in is high and control bit 1 is 1, counting goes on as if stop_in were low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Gated oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the rate register, 1 selects the control register |
| wr_data | input | 7 | Write data |
| stop_in | input | 1 | Stop-mode indication |
| flag_o | output | 1 | Sticky period-end flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- the interrupt tracks the flag and the enable;
- the flag rises only at a period end;
- a period end beats a simultaneous clear;
- a clear with no period end drops the flag;
- a rate write zeroes both counts;
- a frozen stop cycle leaves the counts unchanged;
- a zero selector produces no period end.

Some properties only the bench scenarios can show. These are the exact cycle of each flag-set for several prescaler and modulus settings, the unbroken spacing between periods, the moved deadline after a restart, and the one-cycle delay per frozen stop cycle.

// File: rtl/rti_pkg.sv
`timescale 1ns/1ps
package rti_pkg;
  localparam int MOD_W   = 4;
  localparam int PRE_W   = 3;
  localparam int REG_W   = MOD_W + PRE_W;
  localparam int CTL_IE   = 0;
  localparam int CTL_STAY = 1;
  localparam int CTL_CLR  = 2;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [MOD_W-1:0] modv;
  } rate_t;
endpackage

// File: rtl/rti_prescaler.sv
`timescale 1ns/1ps
module rti_prescaler #(
  parameter int PRE_BASE = 10,
  parameter int PRE_W    = 3,
  parameter int CW       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             tick_o,
  output logic [CW-1:0]    cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;
  int            expo;

  // Terminal count is 2^expo - 1, built as a mask of low ones.
  always_comb begin
    expo = PRE_BASE + int'(pre_sel) - 1;
    term = '0;
    for (int i = 0; i < CW; i++) begin
      term[i] = (i < expo);
    end
  end

  assign tick_o = run && (cnt_q == term);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/rti_divider.sv
`timescale 1ns/1ps
module rti_divider #(
  parameter int MOD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [MOD_W-1:0] modv,
  output logic [MOD_W-1:0] cnt_o,
  output logic             end_o
);
  logic [MOD_W-1:0] cnt_q;

  assign end_o = tick && (cnt_q == modv);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= end_o ? '0 : cnt_q + MOD_W'(1);
    end
  end
endmodule

// File: rtl/rti_flag.sv
`timescale 1ns/1ps
module rti_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic ie_next,
  output logic flag_o,
  output logic irq_o
);
  logic flag_d;

  // Set has priority over clear.
  always_comb begin
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      irq_o  <= flag_d && ie_next;
    end
  end
endmodule

// File: rtl/rti_timer.sv
`timescale 1ns/1ps
module rti_timer
  import rti_pkg::*;
#(
  parameter int PRE_BASE = 10,
  localparam int CW = PRE_BASE + (1 << PRE_W) - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             stop_in,
  output logic             flag_o,
  output logic             irq_o
);
  rate_t            rate_q;
  logic             ie_q;
  logic             stay_q;
  logic             rate_wr;
  logic             ctl_wr;
  logic             ie_d;
  logic             run;
  logic             tick;
  logic             period_end;
  logic [CW-1:0]    pre_cnt;
  logic [MOD_W-1:0] div_cnt;
  logic             unused_bits;

  assign rate_wr     = wr_en && !wr_sel;
  assign ctl_wr      = wr_en && wr_sel;
  assign ie_d        = ctl_wr ? wr_data[CTL_IE] : ie_q;
  assign run         = (rate_q.pre != '0) && (!stop_in || stay_q);
  assign unused_bits = ^wr_data[REG_W-1:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      ie_q   <= 1'b0;
      stay_q <= 1'b0;
    end else begin
      if (rate_wr) rate_q <= rate_t'(wr_data);
      if (ctl_wr) begin
        ie_q   <= wr_data[CTL_IE];
        stay_q <= wr_data[CTL_STAY];
      end
    end
  end

  rti_prescaler #(.PRE_BASE(PRE_BASE), .PRE_W(PRE_W), .CW(CW)) u_pre (
    .clk(clk), .rst(rst), .restart(rate_wr), .run(run),
    .pre_sel(rate_q.pre), .tick_o(tick), .cnt_o(pre_cnt)
  );

  rti_divider #(.MOD_W(MOD_W)) u_div (
    .clk(clk), .rst(rst), .restart(rate_wr), .tick(tick),
    .modv(rate_q.modv), .cnt_o(div_cnt), .end_o(period_end)
  );

  // A restart on the same edge cancels the period end.
  rti_flag u_flag (
    .clk(clk), .rst(rst),
    .set(period_end && !rate_wr),
    .clr(ctl_wr && wr_data[CTL_CLR]),
    .ie_next(ie_d),
    .flag_o(flag_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/rti_timer_chk.sv
`timescale 1ns/1ps
module rti_timer_chk #(
  parameter int CW    = 16,
  parameter int MOD_W = 4,
  parameter int PRE_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rate_wr,
  input logic             ctl_wr,
  input logic             clr_bit,
  input logic             stop_in,
  input logic             stay_q,
  input logic             ie_q,
  input logic [PRE_W-1:0] pre_sel,
  input logic [CW-1:0]    pre_cnt,
  input logic [MOD_W-1:0] div_cnt,
  input logic             period_end,
  input logic             flag_o,
  input logic             irq_o
);
  a_r6_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_o && ie_q));

  a_r2_set_only_at_end: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !period_end) |=> !flag_o);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (period_end && !rate_wr) |=> flag_o);

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && clr_bit && !period_end) |=> !flag_o);

  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    rate_wr |=> (pre_cnt == '0 && div_cnt == '0));

  a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
    (stop_in && !stay_q && !rate_wr) |=> ($stable(pre_cnt) && $stable(div_cnt)));

  a_r5_off: assert property (@(posedge clk) disable iff (rst)
    (pre_sel == '0) |-> !period_end);
endmodule

bind rti_timer rti_timer_chk #(.CW(CW), .MOD_W(rti_pkg::MOD_W), .PRE_W(rti_pkg::PRE_W)) u_chk (
  .clk(clk), .rst(rst), .rate_wr(rate_wr), .ctl_wr(ctl_wr),
  .clr_bit(wr_data[rti_pkg::CTL_CLR]), .stop_in(stop_in), .stay_q(stay_q),
  .ie_q(ie_q), .pre_sel(rate_q.pre), .pre_cnt(pre_cnt), .div_cnt(div_cnt),
  .period_end(period_end), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/rti_timer_tb.sv
`timescale 1ns/1ps
module rti_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [6:0] wr_data = '0;
  logic       stop_in = 1'b0;
  logic       flag_o;
  logic       irq_o;

  int edge_cnt = 0;
  int checks = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];
  logic flag_prev = 1'b0;
  logic ie_sh = 1'b0;
  logic stay_sh = 1'b0;
  bit done = 0;

  rti_timer #(.PRE_BASE(1)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stop_in(stop_in), .flag_o(flag_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: every rising flag is matched against the next expected edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (flag_o && !flag_prev) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected flag set", edge_cnt, -1);
        end else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(edge_cnt == e, t, edge_cnt, e);
        end
      end
      flag_prev <= flag_o;
    end
  end

  // Called at a negedge; returns the write edge number.
  task automatic wr(input bit sel, input logic [6:0] d, output int e);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1 e = edge_cnt;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_edge(input int e);
    while (edge_cnt < e) @(negedge clk);
  endtask

  task automatic set_rate(input int p, input int m, output int e);
    wr(1'b0, {p[2:0], m[3:0]}, e);
  endtask

  task automatic ctl(input bit clr, output int e);
    wr(1'b1, {4'b0, clr, stay_sh, ie_sh}, e);
  endtask

  task automatic push(input int e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic clear_after(input int e);
    int w;
    wait_edge(e + 1);
    chk(flag_o == 1'b1, "R2 flag set before clear", flag_o, 1);
    chk(irq_o == ie_sh, "R6 irq with flag set", irq_o, ie_sh);
    ctl(1'b1, w);
    chk(flag_o == 1'b0, "R7 flag cleared", flag_o, 0);
    chk(irq_o == 1'b0, "R6 irq low after clear", irq_o, 0);
  endtask

  initial begin
    int w, w2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(flag_o == 1'b0, "R1 flag after reset", flag_o, 0);
    chk(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    repeat (40) @(negedge clk);
    chk(flag_o == 1'b0, "R1 timer off after reset", flag_o, 0);

    ie_sh = 1'b1;
    ctl(1'b0, w);

    // R2/R3: p=1 (2), M=2 -> period 6; clears in between do not shift periods
    set_rate(1, 2, w);
    push(w + 6, "R2 first period"); push(w + 12, "R3 no gap"); push(w + 18, "R3 no gap");
    clear_after(w + 6);
    clear_after(w + 12);
    clear_after(w + 18);
    set_rate(0, 0, w2);

    // R5: timer off
    repeat (300) @(negedge clk);
    chk(flag_o == 1'b0, "R5 off stays clear", flag_o, 0);

    // R4: restart moves the deadline
    set_rate(1, 2, w);
    wait_edge(w + 3);
    set_rate(1, 2, w2);
    push(w2 + 6, "R4 restart");
    clear_after(w2 + 6);
    set_rate(0, 0, w2);

    // R2: other prescaler settings
    set_rate(3, 0, w);
    push(w + 8, "R2 p=3 M=0");
    clear_after(w + 8);
    set_rate(0, 0, w2);
    set_rate(7, 1, w);
    push(w + 256, "R2 p=7 M=1");
    clear_after(w + 256);
    set_rate(0, 0, w2);

    // R9: stop freezes for 5 cycles
    set_rate(1, 2, w);
    stop_in = 1'b1;
    repeat (5) @(negedge clk);
    stop_in = 1'b0;
    push(w + 11, "R9 stop freezes");
    clear_after(w + 11);
    set_rate(0, 0, w2);

    // R10: stop-continue keeps counting
    stay_sh = 1'b1;
    ctl(1'b0, w2);
    set_rate(1, 2, w);
    stop_in = 1'b1;
    repeat (5) @(negedge clk);
    stop_in = 1'b0;
    push(w + 6, "R10 runs in stop");
    clear_after(w + 6);
    set_rate(0, 0, w2);
    stay_sh = 1'b0;

    // R6: interrupt masked, then enabled with the flag still set
    ie_sh = 1'b0;
    ctl(1'b0, w2);
    set_rate(1, 2, w);
    push(w + 6, "R6 masked period");
    wait_edge(w + 7);
    chk(flag_o == 1'b1, "R6 flag set while masked", flag_o, 1);
    chk(irq_o == 1'b0, "R6 irq masked", irq_o, 0);
    ie_sh = 1'b1;
    ctl(1'b0, w2);
    chk(irq_o == 1'b1, "R6 irq after enable", irq_o, 1);
    chk(flag_o == 1'b1, "R7 write without clear bit keeps flag", flag_o, 1);
    ctl(1'b1, w2);
    set_rate(0, 0, w2);

    // R8: clear on the same edge as the period end
    set_rate(1, 2, w);
    push(w + 6, "R8 set edge");
    wait_edge(w + 5);
    ctl(1'b1, w2);
    chk(w2 == w + 6, "R8 clear aligned to set edge", w2, w + 6);
    chk(flag_o == 1'b1, "R8 set wins over clear", flag_o, 1);
    ctl(1'b1, w2);
    set_rate(0, 0, w2);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected sets seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule